// File: doc/BRIEF.md
# Wavefront Lane Permutation Network

This block moves 32-bit values between the 64 lanes of a wavefront in a single combinational pass. A 9-bit permutation code selects one of several cross-lane moves. The lanes are grouped into rows of 16, each row holds four banks of four lanes, and a row is also treated as two half-rows of eight. The moves are:

- a free permute inside each group of four lanes
- shifts and rotates inside a row
- a shift or rotate of the whole wavefront by one lane
- a full-row or half-row mirror
- a broadcast of a row's last lane into later rows

For every lane the block produces the moved value and a write-enable. The consuming datapath writes its result only where the write-enable is high.

A lane's source can fall outside its row or outside the wavefront. In that case a fill flag decides what happens. With the flag set, the lane receives zero and still writes. With the flag clear, the lane does not write. Independently of the move, a per-row enable and a per-bank enable suppress writes in whole rows, or in the same bank position of every row.

Top module: `lperm_network`

## Requirements
- R1: For codes 0x000-0x0FF, the lane at position k (0..3) of a group of four reads the lane at (group base + code bits [2k+1:2k]). The source is always valid.
- R2: For codes 0x101-0x10F, with N = code[3:0], a lane at row position p reads row position p+N. The source is invalid when p+N > 15.
- R3: For codes 0x111-0x11F, a lane at row position p reads row position p-N. The source is invalid when p < N.
- R4: For codes 0x121-0x12F, a lane at row position p reads row position (p-N) mod 16. The source is always valid.
- R5: The wavefront-wide moves are:
  - Code 0x130: lane i reads lane i+1, and lane 63 is invalid.
  - Code 0x138: lane i reads lane i-1, and lane 0 is invalid.
  - Code 0x134: lane i reads lane (i+1) mod 64.
  - Code 0x13C: lane i reads lane (i-1) mod 64.
- R6: Code 0x140 makes row position p read row position 15-p. Code 0x141 makes half-row position q read half-row position 7-q.
- R7: Under code 0x142, every lane of row r ≥ 1 reads lane 16r-1, and row 0 keeps its own values. Under code 0x143, every lane of rows 2 and 3 reads lane 31, and rows 0 and 1 keep their own values.
- R8: The output value of a lane with an invalid source is zero. That lane's write-enable equals the fill flag, before masking.
- R9: A lane's write-enable is low when bit (lane/16) of the row enable is zero.
- R10: A lane's write-enable is low when bit ((lane/4) mod 4) of the bank enable is zero.
- R11: Any code from 0x100 to 0x1FF not listed in R2-R7 gives each lane its own value with a valid source. This includes 0x100, 0x110, 0x120, 0x131 and 0x144 upward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_lanes | input | 2048 | Input values; lane i occupies bits [32i+31:32i] |
| perm_code | input | 9 | Permutation code |
| fill_zero | input | 1 | Invalid-source lanes get zero and stay enabled when set |
| row_en | input | 4 | Per-row write enable, bit r for row r |
| bank_en | input | 4 | Per-bank write enable, bit b for bank b of every row |
| out_lanes | output | 2048 | Moved values, same lane packing as the input |
| lane_we | output | 64 | Per-lane write-enable |

## Verification
The hardest situation to reach is a lane whose source falls off the edge of its row or of the wavefront, while its own row and bank are enabled. Only there do the fill flag, the zero value and the write-enable interact.

The stimulus gives every lane a unique value built from its index, so that a wrong source shows up at once. It then sweeps every defined shift and wave code under both fill settings. Each code is first applied with all enables set, so the edge lanes stay visible, and then again with random row and bank enables. The unlisted codes and the quad-permute range are swept in full.

// File: rtl/lperm_pkg.sv
`timescale 1ns/1ps
package lperm_pkg;
   // Code groups selected by perm_code[7:4] when perm_code[8] is set
   typedef enum logic [3:0] {
      GRP_ROW_SHL  = 4'h0,
      GRP_ROW_SHR  = 4'h1,
      GRP_ROW_ROR  = 4'h2,
      GRP_WAVE     = 4'h3,
      GRP_SPECIAL  = 4'h4
   } perm_grp_e;

   // Sub-codes inside the wave group (perm_code[3:0])
   localparam logic [3:0] WAVE_SHL = 4'h0;
   localparam logic [3:0] WAVE_ROL = 4'h4;
   localparam logic [3:0] WAVE_SHR = 4'h8;
   localparam logic [3:0] WAVE_ROR = 4'hC;

   // Sub-codes inside the special group
   localparam logic [3:0] SP_MIRROR      = 4'h0;
   localparam logic [3:0] SP_HALF_MIRROR = 4'h1;
   localparam logic [3:0] SP_BCAST_ROW   = 4'h2;
   localparam logic [3:0] SP_BCAST_31    = 4'h3;

   localparam int QUAD_LANES = 4;
   localparam int CODE_W     = 9;
endpackage

// File: rtl/lperm_src_sel.sv
`timescale 1ns/1ps
// Per-lane source index and validity for one fixed lane position.
module lperm_src_sel
   import lperm_pkg::*;
#(
   parameter int LANE_ID   = 0,
   parameter int NUM_LANES = 64,
   parameter int ROW_LANES = 16,
   parameter int IDX_W     = $clog2(NUM_LANES)
) (
   input  logic [CODE_W-1:0] perm_code,
   output logic [IDX_W-1:0]  src_idx,
   output logic              src_ok
);
   localparam int HALF_LANES = ROW_LANES / 2;
   localparam int ROW        = LANE_ID / ROW_LANES;
   localparam int RPOS       = LANE_ID % ROW_LANES;
   localparam int RBASE      = ROW * ROW_LANES;
   localparam int QPOS       = LANE_ID % QUAD_LANES;
   localparam int QBASE      = LANE_ID - QPOS;
   localparam int HPOS       = LANE_ID % HALF_LANES;
   localparam int HBASE      = LANE_ID - HPOS;

   if (ROW_LANES != 16) begin : g_bad_row
      $error("lperm_src_sel: ROW_LANES must be 16 to match 4-bit shift amounts");
   end

   int   s;
   int   n;
   logic ok;

   always_comb begin
      s  = LANE_ID;
      ok = 1'b1;
      n  = int'(perm_code[3:0]);
      if (!perm_code[8]) begin
         s = QBASE + int'(perm_code[2*QPOS +: 2]);
      end else begin
         case (perm_code[7:4])
            GRP_ROW_SHL: if (n != 0) begin
               if (RPOS + n <= ROW_LANES - 1) s = RBASE + RPOS + n;
               else                           ok = 1'b0;
            end
            GRP_ROW_SHR: if (n != 0) begin
               if (RPOS >= n) s = RBASE + RPOS - n;
               else           ok = 1'b0;
            end
            GRP_ROW_ROR: if (n != 0) begin
               s = RBASE + ((RPOS - n + ROW_LANES) % ROW_LANES);
            end
            GRP_WAVE: begin
               case (perm_code[3:0])
                  WAVE_SHL: begin
                     if (LANE_ID < NUM_LANES - 1) s = LANE_ID + 1;
                     else                         ok = 1'b0;
                  end
                  WAVE_ROL: s = (LANE_ID + 1) % NUM_LANES;
                  WAVE_SHR: begin
                     if (LANE_ID > 0) s = LANE_ID - 1;
                     else             ok = 1'b0;
                  end
                  WAVE_ROR: s = (LANE_ID + NUM_LANES - 1) % NUM_LANES;
                  default:  s = LANE_ID;
               endcase
            end
            GRP_SPECIAL: begin
               case (perm_code[3:0])
                  SP_MIRROR:      s = RBASE + ROW_LANES - 1 - RPOS;
                  SP_HALF_MIRROR: s = HBASE + HALF_LANES - 1 - HPOS;
                  SP_BCAST_ROW:   if (ROW >= 1) s = RBASE - 1;
                  SP_BCAST_31:    if (ROW >= 2) s = 2 * ROW_LANES - 1;
                  default:        s = LANE_ID;
               endcase
            end
            default: s = LANE_ID;
         endcase
      end
   end

   assign src_idx = IDX_W'(s);
   assign src_ok  = ok;
endmodule

// File: rtl/lperm_lane_gate.sv
`timescale 1ns/1ps
// Write-enable gating for one lane: validity, fill policy, row and bank masks.
module lperm_lane_gate #(
   parameter int LANE_ID   = 0,
   parameter int ROW_LANES = 16,
   parameter int NUM_ROWS  = 4,
   parameter int NUM_BANKS = 4,
   parameter int BANK_LANES = 4
) (
   input  logic                 src_ok,
   input  logic                 fill_zero,
   input  logic [NUM_ROWS-1:0]  row_en,
   input  logic [NUM_BANKS-1:0] bank_en,
   output logic                 we
);
   localparam int ROW_SEL  = LANE_ID / ROW_LANES;
   localparam int BANK_SEL = (LANE_ID / BANK_LANES) % NUM_BANKS;

   assign we = (src_ok | fill_zero) & row_en[ROW_SEL] & bank_en[BANK_SEL];
endmodule

// File: rtl/lperm_network.sv
`timescale 1ns/1ps
module lperm_network
   import lperm_pkg::*;
#(
   parameter int NUM_LANES = 64,
   parameter int ROW_LANES = 16,
   parameter int DATA_W    = 32,
   parameter int NUM_ROWS  = NUM_LANES / ROW_LANES,
   parameter int NUM_BANKS = ROW_LANES / QUAD_LANES
) (
   input  logic [NUM_LANES*DATA_W-1:0] src_lanes,
   input  logic [CODE_W-1:0]           perm_code,
   input  logic                        fill_zero,
   input  logic [NUM_ROWS-1:0]         row_en,
   input  logic [NUM_BANKS-1:0]        bank_en,
   output logic [NUM_LANES*DATA_W-1:0] out_lanes,
   output logic [NUM_LANES-1:0]        lane_we
);
   localparam int IDX_W = $clog2(NUM_LANES);

   if (NUM_LANES % ROW_LANES != 0) begin : g_bad_lanes
      $error("lperm_network: NUM_LANES must be a multiple of ROW_LANES");
   end
   if (NUM_ROWS * ROW_LANES != NUM_LANES) begin : g_bad_rows
      $error("lperm_network: NUM_ROWS inconsistent with lane count");
   end
   if (NUM_BANKS * QUAD_LANES != ROW_LANES) begin : g_bad_banks
      $error("lperm_network: NUM_BANKS inconsistent with row width");
   end

   for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
      logic [IDX_W-1:0]  idx;
      logic              ok;
      logic [DATA_W-1:0] picked;

      lperm_src_sel #(
         .LANE_ID   (l),
         .NUM_LANES (NUM_LANES),
         .ROW_LANES (ROW_LANES),
         .IDX_W     (IDX_W)
      ) u_sel (
         .perm_code (perm_code),
         .src_idx   (idx),
         .src_ok    (ok)
      );

      always_comb begin
         picked = src_lanes[int'(idx)*DATA_W +: DATA_W];
      end

      assign out_lanes[l*DATA_W +: DATA_W] = ok ? picked : '0;

      lperm_lane_gate #(
         .LANE_ID    (l),
         .ROW_LANES  (ROW_LANES),
         .NUM_ROWS   (NUM_ROWS),
         .NUM_BANKS  (NUM_BANKS),
         .BANK_LANES (QUAD_LANES)
      ) u_gate (
         .src_ok    (ok),
         .fill_zero (fill_zero),
         .row_en    (row_en),
         .bank_en   (bank_en),
         .we        (lane_we[l])
      );
   end
endmodule

// File: rtl/lperm_network_chk.sv
`timescale 1ns/1ps
module lperm_network_chk
   import lperm_pkg::*;
#(
   parameter int NUM_LANES = 64,
   parameter int ROW_LANES = 16,
   parameter int DATA_W    = 32,
   parameter int NUM_ROWS  = NUM_LANES / ROW_LANES,
   parameter int NUM_BANKS = ROW_LANES / QUAD_LANES
) (
   input logic [CODE_W-1:0]           perm_code,
   input logic                        fill_zero,
   input logic [NUM_ROWS-1:0]         row_en,
   input logic [NUM_BANKS-1:0]        bank_en,
   input logic [NUM_LANES*DATA_W-1:0] out_lanes,
   input logic [NUM_LANES-1:0]        lane_we
);
   always_comb begin
      for (int l = 0; l < NUM_LANES; l++) begin
         // R9: disabled row never writes
         p_row_off_no_write_r9: assert (row_en[l / ROW_LANES] || !lane_we[l])
            else $error("row-disabled lane %0d writes", l);
         // R10: disabled bank never writes
         p_bank_off_no_write_r10: assert (bank_en[(l / QUAD_LANES) % NUM_BANKS] || !lane_we[l])
            else $error("bank-disabled lane %0d writes", l);
         // R8: with fill set, every unmasked lane writes
         p_fill_keeps_write_r8: assert (!(fill_zero && row_en[l / ROW_LANES]
                                   && bank_en[(l / QUAD_LANES) % NUM_BANKS]) || lane_we[l])
            else $error("fill set but lane %0d not writing", l);
         // R1: quad permutes never invalidate an unmasked lane
         p_quad_valid_r1: assert (!(!perm_code[8] && row_en[l / ROW_LANES]
                                   && bank_en[(l / QUAD_LANES) % NUM_BANKS]) || lane_we[l])
            else $error("quad permute dropped lane %0d", l);
         // R2: left-shift past the row edge yields zero
         p_shl_edge_zero_r2: assert (!(perm_code[8:4] == 5'b10000 && perm_code[3:0] != 4'h0
                                   && (l % ROW_LANES) + int'(perm_code[3:0]) > ROW_LANES - 1)
                                   || out_lanes[l*DATA_W +: DATA_W] == '0)
            else $error("shifted-out lane %0d not zero", l);
      end
   end
endmodule

bind lperm_network lperm_network_chk #(
   .NUM_LANES (NUM_LANES),
   .ROW_LANES (ROW_LANES),
   .DATA_W    (DATA_W),
   .NUM_ROWS  (NUM_ROWS),
   .NUM_BANKS (NUM_BANKS)
) u_chk (.*);

// File: tb/lperm_network_bench.sv
`timescale 1ns/1ps
module lperm_network_bench;
   localparam int LANES = 64;
   localparam int DW    = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic [LANES*DW-1:0] src_lanes;
   logic [8:0]          perm_code;
   logic                fill_zero;
   logic [3:0]          row_en;
   logic [3:0]          bank_en;
   logic [LANES*DW-1:0] out_lanes;
   logic [LANES-1:0]    lane_we;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;

   lperm_network u_lperm_network (
      .src_lanes (src_lanes),
      .perm_code (perm_code),
      .fill_zero (fill_zero),
      .row_en    (row_en),
      .bank_en   (bank_en),
      .out_lanes (out_lanes),
      .lane_we   (lane_we)
   );

   function automatic logic [DW-1:0] lane_val(int i);
      return {8'hC3, 8'(i), 8'(i * 7 + 1), 8'(~i)};
   endfunction

   // Independent model of the source selection, written from the requirements
   function automatic void model(int lane, int code, output int src, output bit ok);
      int row = lane / 16;
      int p   = lane % 16;
      int n   = code % 16;
      src = lane;
      ok  = 1'b1;
      if (code < 256) begin
         src = (lane / 4) * 4 + ((code >> (2 * (lane % 4))) % 4);
      end else if (code >= 'h101 && code <= 'h10F) begin
         if (p + n < 16) src = row * 16 + p + n; else ok = 1'b0;
      end else if (code >= 'h111 && code <= 'h11F) begin
         if (p >= n) src = row * 16 + p - n; else ok = 1'b0;
      end else if (code >= 'h121 && code <= 'h12F) begin
         src = row * 16 + (p + 16 - n) % 16;
      end else if (code == 'h130) begin
         if (lane < 63) src = lane + 1; else ok = 1'b0;
      end else if (code == 'h134) begin
         src = (lane + 1) % 64;
      end else if (code == 'h138) begin
         if (lane > 0) src = lane - 1; else ok = 1'b0;
      end else if (code == 'h13C) begin
         src = (lane + 63) % 64;
      end else if (code == 'h140) begin
         src = row * 16 + 15 - p;
      end else if (code == 'h141) begin
         src = (lane / 8) * 8 + 7 - lane % 8;
      end else if (code == 'h142) begin
         if (row > 0) src = row * 16 - 1;
      end else if (code == 'h143) begin
         if (row >= 2) src = 31;
      end
   endfunction

   task automatic apply(int code, bit fz, logic [3:0] rm, logic [3:0] bm);
      @(posedge clk);
      perm_code = 9'(code);
      fill_zero = fz;
      row_en    = rm;
      bank_en   = bm;
      @(negedge clk);
   endtask

   task automatic check_all(string req);
      int code = int'(perm_code);
      for (int l = 0; l < LANES; l++) begin
         int src;
         bit ok;
         logic [DW-1:0] exp_v;
         logic exp_we;
         model(l, code, src, ok);
         exp_v  = ok ? lane_val(src) : '0;
         exp_we = (ok | fill_zero) & row_en[l / 16] & bank_en[(l / 4) % 4];
         n_checks++;
         if (out_lanes[l*DW +: DW] !== exp_v || lane_we[l] !== exp_we) begin
            n_fails++;
            $display("FAIL %s code=%03h lane %0d: actual val=%08h we=%b expected val=%08h we=%b",
                     req, code, l, out_lanes[l*DW +: DW], lane_we[l], exp_v, exp_we);
         end
      end
   endtask

   task automatic sweep(int lo, int hi, string req);
      for (int c = lo; c <= hi; c++) begin
         for (int f = 0; f < 2; f++) begin
            apply(c, f[0], 4'hF, 4'hF);
            check_all(req);
            apply(c, f[0], 4'($urandom), 4'($urandom));
            check_all(req);
         end
      end
   endtask

   task automatic t_idle();
      apply(0, 1'b0, 4'h0, 4'h0);
      check_all("R9 idle");
   endtask

   task automatic t_quad();
      for (int c = 0; c < 256; c++) begin
         apply(c, c[0], 4'hF, 4'hF);
         check_all("R1");
      end
   endtask

   task automatic t_row_shl(); sweep('h101, 'h10F, "R2 R8"); endtask
   task automatic t_row_shr(); sweep('h111, 'h11F, "R3 R8"); endtask
   task automatic t_row_ror(); sweep('h121, 'h12F, "R4");    endtask

   task automatic t_wave();
      sweep('h130, 'h130, "R5 R8");
      sweep('h134, 'h134, "R5");
      sweep('h138, 'h138, "R5 R8");
      sweep('h13C, 'h13C, "R5");
   endtask

   task automatic t_mirror(); sweep('h140, 'h141, "R6"); endtask
   task automatic t_bcast();  sweep('h142, 'h143, "R7"); endtask

   task automatic t_masks();
      for (int m = 0; m < 16; m++) begin
         apply('h134, 1'b0, 4'(m), 4'hF);
         check_all("R9");
         apply('h134, 1'b0, 4'hF, 4'(m));
         check_all("R10");
      end
   endtask

   task automatic t_unlisted();
      sweep('h100, 'h100, "R11");
      sweep('h110, 'h110, "R11");
      sweep('h120, 'h120, "R11");
      sweep('h131, 'h133, "R11");
      sweep('h135, 'h137, "R11");
      sweep('h139, 'h13B, "R11");
      sweep('h13D, 'h13F, "R11");
      for (int c = 'h144; c <= 'h1FF; c++) begin
         apply(c, 1'b0, 4'($urandom), 4'($urandom));
         check_all("R11");
      end
   endtask

   initial begin
      for (int i = 0; i < LANES; i++) src_lanes[i*DW +: DW] = lane_val(i);
      perm_code = '0;
      fill_zero = 1'b0;
      row_en    = '0;
      bank_en   = '0;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      t_idle();
      t_quad();
      t_row_shl();
      t_row_shr();
      t_row_ror();
      t_wave();
      t_mirror();
      t_bcast();
      t_masks();
      t_unlisted();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fails++;
         $display("FAIL watchdog: run incomplete, actual timeout expected finish");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end
endmodule